// File: doc/BRIEF.md
# Wave Dispatcher with Register-Budget Occupancy Control

This block accepts a launch command (a thread count, a per-wave register demand and a start program counter) and splits the threads into waves of a fixed lane count. It places each wave into a free residency slot of a single compute unit. A wave is placed only when a slot is free and a contiguous block of the register file can hold the wave's register demand. Because both limits apply, a shader with a large register demand reaches a lower occupancy than the slot count alone would permit.

Each placed wave is reported for one cycle with its slot number, the register offset of its block, an active-lane mask and the program counter it starts from. A retire pulse naming a slot releases that slot and its register block. A placement that is waiting for space can then use them in the following cycle. The launch side uses a valid/ready handshake, and ready stays low until every wave of the accepted command has been placed. A count of resident waves is available at all times.

Top module: `wave_dispatch`

## Requirements
- R1: After reset, launch_ready is 1, wave_valid is 0 and occupancy is 0.
- R2: A command of N threads yields ceil(N/64) waves. Bit i of wave_mask enables lane i. Every wave has all 64 bits set except the last wave of a command whose N is not a multiple of 64, which has only its low N mod 64 bits set.
- R3: A wave takes the lowest-numbered free slot (slots 0 to 9). No more than 10 waves are ever resident, and no wave is issued while all slots are occupied.
- R4: A wave reserves its register demand rounded up to a multiple of 4, with a minimum of 4. The reservation is one contiguous block at the lowest-addressed start that fits. wave_base is the block's first register, a multiple of 4. When no block fits, the wave waits even if a slot is free.
- R5: Every wave of a command reports that command's start program counter on wave_pc.
- R6: A command with a nonzero thread count is accepted on a clock edge where launch_valid and launch_ready are both 1. launch_ready is then 0 until the cycle after its last wave is issued. A command with zero threads is accepted, issues no wave and leaves launch_ready at 1.
- R7: wave_valid is 1 for exactly one cycle per placed wave, in every cycle where a command is in progress and both a slot and a register block are available. At most one wave is placed per cycle.
- R8: A retire pulse on an occupied slot frees that slot and its register block at that clock edge. A waiting wave may use them in the next cycle. A retire pulse naming a free slot or a slot number of 10 or above has no effect.
- R9: occupancy equals the number of resident waves and changes at the edge where a wave is placed or retired.
- R10: A placement and a retire of a different slot in the same cycle both take effect, leaving occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| launch_valid | input | 1 | Launch command offered |
| launch_threads | input | 16 | Total thread count of the command |
| launch_regs | input | 8 | Registers needed by each wave |
| launch_pc | input | 32 | Start program counter |
| launch_ready | output | 1 | Dispatcher can take a command |
| wave_valid | output | 1 | A wave is placed this cycle |
| wave_slot | output | 4 | Slot taken by the wave |
| wave_base | output | 8 | First register of the wave's block |
| wave_mask | output | 64 | Active-lane mask of the wave |
| wave_pc | output | 32 | Program counter of the wave |
| retire_valid | input | 1 | Retire pulse |
| retire_slot | input | 4 | Slot being retired |
| occupancy | output | 4 | Number of resident waves |

## Verification
The wave outputs are decoded from registered state within the cycle, so a wave appears in the cycle after its command is accepted, and in the cycle after a retire that unblocks it. The slot map, register map and occupancy change at the edge that ends the placing or retiring cycle. The bench reference model advances on the rising edge from the same inputs. Every output is compared against it 1 ns after each falling edge, when both the model state and the decoded outputs are settled. Directed checks read the logged waves and occupancy at the same sampling point, with counts derived by hand from R2, R4 and R8.

// File: rtl/wd_pkg.sv
package wd_pkg;

   typedef enum logic {
      WD_IDLE = 1'b0,
      WD_CUT  = 1'b1
   } cut_state_e;

   // Register demand rounded up to whole granules, never less than one.
   function automatic int granules_for(int regs, int gran_shift);
      int g;
      g = (regs + (1 << gran_shift) - 1) >> gran_shift;
      if (g == 0) g = 1;
      return g;
   endfunction

endpackage

// File: rtl/wd_wave_cutter.sv
module wd_wave_cutter
   import wd_pkg::*;
#(
   parameter int LANES  = 64,
   parameter int THR_W  = 16,
   parameter int DEM_W  = 8,
   parameter int PC_W   = 32,
   parameter int GLEN_W = 7,
   parameter int GSH    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch_valid,
   input  logic [THR_W-1:0]  launch_threads,
   input  logic [DEM_W-1:0]  launch_regs,
   input  logic [PC_W-1:0]   launch_pc,
   input  logic              place,
   output logic              launch_ready,
   output logic              active,
   output logic [GLEN_W-1:0] need,
   output logic [LANES-1:0]  lane_mask,
   output logic [PC_W-1:0]   cur_pc
);

   if (LANES < 1) begin : g_bad_lanes
      $error("wd_wave_cutter: LANES must be at least 1");
   end
   if (THR_W < $clog2(LANES + 1)) begin : g_bad_thr
      $error("wd_wave_cutter: THR_W too narrow for one wave");
   end

   cut_state_e       st;
   logic [THR_W-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= WD_IDLE;
         remain <= '0;
         need   <= '0;
         cur_pc <= '0;
      end else if (st == WD_IDLE) begin
         if (launch_valid && launch_threads != '0) begin
            st     <= WD_CUT;
            remain <= launch_threads;
            need   <= GLEN_W'(granules_for(int'(launch_regs), GSH));
            cur_pc <= launch_pc;
         end
      end else if (place) begin
         if (32'(remain) <= 32'(LANES)) st <= WD_IDLE;
         else remain <= remain - THR_W'(LANES);
      end
   end

   assign launch_ready = (st == WD_IDLE);
   assign active       = (st == WD_CUT);

   always_comb begin
      for (int i = 0; i < LANES; i++) lane_mask[i] = (32'(i) < 32'(remain));
   end

   // R2: a presented mask is nonempty and a contiguous run from lane 0
   assert_mask_shape_R2: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (lane_mask != '0) && ((lane_mask & (lane_mask + 1'b1)) == '0));

   // R6: accepting a nonempty command drops ready on the next cycle
   assert_ready_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (launch_valid && launch_ready && launch_threads != '0) |=> !launch_ready);

endmodule

// File: rtl/wd_slot_pool.sv
module wd_slot_pool #(
   parameter int NSLOT  = 10,
   parameter int SLOT_W = 4,
   parameter int GIDX_W = 6,
   parameter int GLEN_W = 7,
   parameter int OCC_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_en,
   input  logic [GIDX_W-1:0] alloc_base,
   input  logic [GLEN_W-1:0] alloc_len,
   input  logic              retire_en,
   input  logic [SLOT_W-1:0] retire_id,
   output logic              free_found,
   output logic [SLOT_W-1:0] free_id,
   output logic              rel_en,
   output logic [GIDX_W-1:0] rel_base,
   output logic [GLEN_W-1:0] rel_len,
   output logic [OCC_W-1:0]  occupancy
);

   if (NSLOT < 2 || SLOT_W < $clog2(NSLOT)) begin : g_bad_slots
      $error("wd_slot_pool: slot count or id width invalid");
   end
   if (OCC_W < $clog2(NSLOT + 1)) begin : g_bad_occ
      $error("wd_slot_pool: OCC_W too narrow");
   end

   logic [NSLOT-1:0]  used;
   logic [NSLOT-1:0]  hit;
   logic [NSLOT-1:0]  alloc_vec;
   logic [GIDX_W-1:0] base_q [NSLOT];
   logic [GLEN_W-1:0] len_q  [NSLOT];

   for (genvar i = 0; i < NSLOT; i++) begin : g_slot
      assign hit[i]       = retire_en && (retire_id == SLOT_W'(i)) && used[i];
      assign alloc_vec[i] = alloc_en && (free_id == SLOT_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            base_q[i] <= '0;
            len_q[i]  <= '0;
         end else if (alloc_vec[i]) begin
            base_q[i] <= alloc_base;
            len_q[i]  <= alloc_len;
         end
      end
   end

   always_comb begin
      rel_base = '0;
      rel_len  = '0;
      for (int i = 0; i < NSLOT; i++) begin
         if (hit[i]) begin
            rel_base = rel_base | base_q[i];
            rel_len  = rel_len | len_q[i];
         end
      end
   end

   assign rel_en = |hit;

   always_comb begin
      free_found = 1'b0;
      free_id    = '0;
      for (int i = NSLOT - 1; i >= 0; i--) begin
         if (!used[i]) begin
            free_found = 1'b1;
            free_id    = SLOT_W'(i);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         used      <= '0;
         occupancy <= '0;
      end else begin
         used      <= (used & ~hit) | alloc_vec;
         occupancy <= occupancy + OCC_W'(alloc_en) - OCC_W'(rel_en);
      end
   end

   // R9: the running count agrees with the slot map
   assert_occ_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
      32'(occupancy) == $countones(used));

   // R3: never more resident waves than slots
   assert_occ_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      32'(occupancy) <= NSLOT);

   // R3: a placement only happens when a free slot exists
   assert_alloc_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_en |-> free_found && !used[free_id]);

   // R10: simultaneous placement and retire leave the count unchanged
   assert_swap_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_en && rel_en) |=> occupancy == $past(occupancy));

endmodule

// File: rtl/wd_reg_alloc.sv
module wd_reg_alloc #(
   parameter int NGRAN  = 64,
   parameter int GIDX_W = 6,
   parameter int GLEN_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [GLEN_W-1:0] need,
   input  logic              alloc_en,
   input  logic              rel_en,
   input  logic [GIDX_W-1:0] rel_base,
   input  logic [GLEN_W-1:0] rel_len,
   output logic              fit_found,
   output logic [GIDX_W-1:0] fit_base
);

   if (NGRAN < 2 || GIDX_W < $clog2(NGRAN) || GLEN_W < $clog2(NGRAN + 1)) begin : g_bad_map
      $error("wd_reg_alloc: granule count or widths invalid");
   end

   logic [NGRAN-1:0] used;
   logic [NGRAN-1:0] free_map;
   logic [NGRAN-1:0] need_mask;
   logic [NGRAN-1:0] rel_span;
   logic [NGRAN-1:0] fits;
   logic [NGRAN-1:0] alloc_vec;
   logic [NGRAN-1:0] rel_vec;

   assign free_map = ~used;

   always_comb begin
      for (int i = 0; i < NGRAN; i++) begin
         need_mask[i] = (32'(i) < 32'(need));
         rel_span[i]  = (32'(i) < 32'(rel_len));
      end
   end

   // One window comparator per candidate start granule.
   for (genvar s = 0; s < NGRAN; s++) begin : g_start
      assign fits[s] = (32'(s) + 32'(need) <= 32'(NGRAN)) &&
                       (((free_map >> s) & need_mask) == need_mask);
   end

   always_comb begin
      fit_found = 1'b0;
      fit_base  = '0;
      for (int s = NGRAN - 1; s >= 0; s--) begin
         if (fits[s]) begin
            fit_found = 1'b1;
            fit_base  = GIDX_W'(s);
         end
      end
   end

   assign alloc_vec = alloc_en ? (need_mask << fit_base) : '0;
   assign rel_vec   = rel_en ? (rel_span << rel_base) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) used <= '0;
      else        used <= (used & ~rel_vec) | alloc_vec;
   end

   // R4: a new block never overlaps registers already held
   assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_en |-> (used & alloc_vec) == '0);

   // R8: a released block was held in full
   assert_release_owned_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rel_en |-> (used & rel_vec) == rel_vec);

endmodule

// File: rtl/wave_dispatch.sv
module wave_dispatch #(
   parameter int LANES   = 64,
   parameter int NSLOT   = 10,
   parameter int RF_REGS = 256,
   parameter int GRAN    = 4,
   parameter int THR_W   = 16,
   parameter int PC_W    = 32
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         launch_valid,
   input  logic [THR_W-1:0]             launch_threads,
   input  logic [$clog2(RF_REGS)-1:0]   launch_regs,
   input  logic [PC_W-1:0]              launch_pc,
   output logic                         launch_ready,
   output logic                         wave_valid,
   output logic [$clog2(NSLOT)-1:0]     wave_slot,
   output logic [$clog2(RF_REGS)-1:0]   wave_base,
   output logic [LANES-1:0]             wave_mask,
   output logic [PC_W-1:0]              wave_pc,
   input  logic                         retire_valid,
   input  logic [$clog2(NSLOT)-1:0]     retire_slot,
   output logic [$clog2(NSLOT+1)-1:0]   occupancy
);

   localparam int NGRAN  = RF_REGS / GRAN;
   localparam int GSH    = $clog2(GRAN);
   localparam int GIDX_W = $clog2(NGRAN);
   localparam int GLEN_W = $clog2(NGRAN + 1);
   localparam int SLOT_W = $clog2(NSLOT);
   localparam int DEM_W  = $clog2(RF_REGS);
   localparam int OCC_W  = $clog2(NSLOT + 1);

   if (GRAN < 2 || (GRAN & (GRAN - 1)) != 0) begin : g_bad_gran
      $error("wave_dispatch: GRAN must be a power of two of at least 2");
   end
   if (RF_REGS < 2 * GRAN || (RF_REGS & (RF_REGS - 1)) != 0) begin : g_bad_rf
      $error("wave_dispatch: RF_REGS must be a power of two holding two granules");
   end

   logic              cut_active;
   logic [GLEN_W-1:0] need;
   logic              free_found;
   logic [SLOT_W-1:0] free_id;
   logic              fit_found;
   logic [GIDX_W-1:0] fit_base;
   logic              rel_en;
   logic [GIDX_W-1:0] rel_base;
   logic [GLEN_W-1:0] rel_len;
   logic              place;

   assign place = cut_active && free_found && fit_found;

   wd_wave_cutter #(
      .LANES(LANES), .THR_W(THR_W), .DEM_W(DEM_W), .PC_W(PC_W),
      .GLEN_W(GLEN_W), .GSH(GSH)
   ) cutter_i (
      .clk(clk), .rst_n(rst_n),
      .launch_valid(launch_valid), .launch_threads(launch_threads),
      .launch_regs(launch_regs), .launch_pc(launch_pc),
      .place(place), .launch_ready(launch_ready), .active(cut_active),
      .need(need), .lane_mask(wave_mask), .cur_pc(wave_pc)
   );

   wd_slot_pool #(
      .NSLOT(NSLOT), .SLOT_W(SLOT_W), .GIDX_W(GIDX_W),
      .GLEN_W(GLEN_W), .OCC_W(OCC_W)
   ) slots_i (
      .clk(clk), .rst_n(rst_n),
      .alloc_en(place), .alloc_base(fit_base), .alloc_len(need),
      .retire_en(retire_valid), .retire_id(retire_slot),
      .free_found(free_found), .free_id(free_id),
      .rel_en(rel_en), .rel_base(rel_base), .rel_len(rel_len),
      .occupancy(occupancy)
   );

   wd_reg_alloc #(
      .NGRAN(NGRAN), .GIDX_W(GIDX_W), .GLEN_W(GLEN_W)
   ) regs_i (
      .clk(clk), .rst_n(rst_n),
      .need(need), .alloc_en(place),
      .rel_en(rel_en), .rel_base(rel_base), .rel_len(rel_len),
      .fit_found(fit_found), .fit_base(fit_base)
   );

   assign wave_valid = place;
   assign wave_slot  = free_id;
   assign wave_base  = {fit_base, {GSH{1'b0}}};

   // R7: a wave is only presented while the launch side is closed
   assert_wave_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wave_valid |-> !launch_ready);

   // R9: a lone placement raises occupancy by one
   assert_occ_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wave_valid && !retire_valid) |=> occupancy == $past(occupancy) + 1'b1);

endmodule

// File: tb/wave_dispatch_tb.sv
`timescale 1ns/1ps
module wave_dispatch_tb_top;

   localparam int NS = 10;
   localparam int NG = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        launch_valid = 1'b0;
   logic [15:0] launch_threads = '0;
   logic [7:0]  launch_regs = '0;
   logic [31:0] launch_pc = '0;
   logic        launch_ready;
   logic        wave_valid;
   logic [3:0]  wave_slot;
   logic [7:0]  wave_base;
   logic [63:0] wave_mask;
   logic [31:0] wave_pc;
   logic        retire_valid = 1'b0;
   logic [3:0]  retire_slot = '0;
   logic [3:0]  occupancy;

   always #2 clk = ~clk;

   wave_dispatch dut_i (
      .clk(clk), .rst_n(rst_n),
      .launch_valid(launch_valid), .launch_threads(launch_threads),
      .launch_regs(launch_regs), .launch_pc(launch_pc),
      .launch_ready(launch_ready), .wave_valid(wave_valid),
      .wave_slot(wave_slot), .wave_base(wave_base), .wave_mask(wave_mask),
      .wave_pc(wave_pc), .retire_valid(retire_valid),
      .retire_slot(retire_slot), .occupancy(occupancy)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit running = 1'b0;

   task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s act=%0h exp=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   // Behavioural reference model
   bit          m_used [NS];
   int          m_base [NS];
   int          m_len  [NS];
   bit          m_g    [NG];
   bit          m_busy;
   int          m_remain;
   int          m_need;
   logic [31:0] m_pc;

   function automatic void predict(output bit pv, output int ps, output int pst);
      ps = -1; pst = -1; pv = 1'b0;
      if (!m_busy) return;
      for (int i = 0; i < NS; i++) if (!m_used[i] && ps < 0) ps = i;
      for (int s = 0; s + m_need <= NG; s++) begin
         bit ok = 1'b1;
         for (int k = 0; k < m_need; k++) if (m_g[s + k]) ok = 1'b0;
         if (ok && pst < 0) pst = s;
      end
      pv = (ps >= 0) && (pst >= 0);
   endfunction

   function automatic int m_occ();
      int c = 0;
      for (int i = 0; i < NS; i++) if (m_used[i]) c++;
      return c;
   endfunction

   function automatic logic [63:0] m_mask();
      if (m_remain >= 64) return '1;
      return (64'h1 << m_remain) - 64'h1;
   endfunction

   always @(posedge clk) begin
      bit pv; int ps; int pst;
      if (!rst_n) begin
         for (int i = 0; i < NS; i++) begin m_used[i] = 0; m_base[i] = 0; m_len[i] = 0; end
         for (int g = 0; g < NG; g++) m_g[g] = 0;
         m_busy = 0; m_remain = 0; m_need = 0; m_pc = '0;
      end else begin
         predict(pv, ps, pst);
         if (retire_valid && int'(retire_slot) < NS && m_used[retire_slot]) begin
            for (int k = 0; k < m_len[retire_slot]; k++) m_g[m_base[retire_slot] + k] = 0;
            m_used[retire_slot] = 0;
         end
         if (pv) begin
            m_used[ps] = 1; m_base[ps] = pst; m_len[ps] = m_need;
            for (int k = 0; k < m_need; k++) m_g[pst + k] = 1;
            if (m_remain <= 64) m_busy = 0;
            else m_remain -= 64;
         end else if (!m_busy && launch_valid && launch_threads != 0) begin
            m_busy = 1;
            m_remain = int'(launch_threads);
            m_need = (int'(launch_regs) + 3) / 4;
            if (m_need == 0) m_need = 1;
            m_pc = launch_pc;
         end
      end
   end

   int          q_slot [$];
   int          q_base [$];
   logic [63:0] q_mask [$];
   logic [31:0] q_pc   [$];

   // Per-cycle comparison against the model
   always begin
      bit pv; int ps; int pst;
      @(negedge clk);
      #1;
      if (rst_n && running) begin
         predict(pv, ps, pst);
         chk(launch_ready == !m_busy, "R6", "launch_ready", 64'(launch_ready), 64'(!m_busy));
         chk(wave_valid == pv, "R7", "wave_valid", 64'(wave_valid), 64'(pv));
         if (pv && wave_valid) begin
            chk(int'(wave_slot) == ps, "R3", "wave_slot", 64'(wave_slot), 64'(ps));
            chk(int'(wave_base) == pst * 4, "R4", "wave_base", 64'(wave_base), 64'(pst * 4));
            chk(wave_mask == m_mask(), "R2", "wave_mask", wave_mask, m_mask());
            chk(wave_pc == m_pc, "R5", "wave_pc", 64'(wave_pc), 64'(m_pc));
         end
         chk(int'(occupancy) == m_occ(), "R9", "occupancy", 64'(occupancy), 64'(m_occ()));
         if (wave_valid) begin
            q_slot.push_back(int'(wave_slot));
            q_base.push_back(int'(wave_base));
            q_mask.push_back(wave_mask);
            q_pc.push_back(wave_pc);
         end
      end
   end

   task automatic clear_log();
      q_slot.delete(); q_base.delete(); q_mask.delete(); q_pc.delete();
   endtask

   task automatic launch(int thr, int regs, logic [31:0] pc);
      @(negedge clk);
      while (m_busy) @(negedge clk);
      launch_valid = 1'b1;
      launch_threads = 16'(thr);
      launch_regs = 8'(regs);
      launch_pc = pc;
      @(negedge clk);
      launch_valid = 1'b0;
   endtask

   task automatic retire(int s);
      @(negedge clk);
      retire_valid = 1'b1;
      retire_slot = 4'(s);
      @(negedge clk);
      retire_valid = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic settle();
      for (int i = 0; i < 500 && m_busy; i++) @(negedge clk);
      idle(2);
   endtask

   task automatic main_seq();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      running = 1'b1;
      @(negedge clk); #1;
      // R1 reset state
      chk(launch_ready == 1'b1, "R1", "ready after reset", 64'(launch_ready), 64'd1);
      chk(wave_valid == 1'b0, "R1", "wave_valid after reset", 64'(wave_valid), 64'd0);
      chk(occupancy == 4'd0, "R1", "occupancy after reset", 64'(occupancy), 64'd0);

      // R2 partial last wave, R4 rounding 10 -> 12 registers
      clear_log();
      launch(100, 10, 32'h1000);
      settle();
      chk(q_slot.size() == 2, "R2", "wave count 100 thr", 64'(q_slot.size()), 64'd2);
      chk(q_mask[0] == '1, "R2", "first mask", q_mask[0], '1);
      chk(q_mask[1] == (64'h1 << 36) - 64'h1, "R2", "tail mask", q_mask[1], (64'h1 << 36) - 64'h1);
      chk(q_base[1] == 12, "R4", "second base", 64'(q_base[1]), 64'd12);
      chk(q_slot[1] == 1, "R3", "second slot", 64'(q_slot[1]), 64'd1);
      chk(q_pc[1] == 32'h1000, "R5", "pc of second wave", 64'(q_pc[1]), 64'h1000);
      chk(occupancy == 4'd2, "R9", "occupancy two", 64'(occupancy), 64'd2);
      retire(0); retire(1); idle(1);
      chk(occupancy == 4'd0, "R8", "occupancy after retire", 64'(occupancy), 64'd0);

      // R6 zero-thread command
      clear_log();
      launch(0, 8, 32'h55);
      idle(3);
      chk(q_slot.size() == 0, "R6", "zero threads waves", 64'(q_slot.size()), 64'd0);
      chk(launch_ready == 1'b1, "R6", "zero threads ready", 64'(launch_ready), 64'd1);

      // R3 slot limit, R8 retry after retire
      clear_log();
      launch(650, 0, 32'h2000);
      idle(20);
      chk(q_slot.size() == 10, "R3", "waves at slot limit", 64'(q_slot.size()), 64'd10);
      chk(occupancy == 4'd10, "R3", "occupancy full", 64'(occupancy), 64'd10);
      chk(launch_ready == 1'b0, "R6", "ready while waiting", 64'(launch_ready), 64'd0);
      chk(q_base[9] == 36, "R4", "zero demand base", 64'(q_base[9]), 64'd36);
      retire(3);
      idle(3);
      chk(q_slot.size() == 11, "R8", "wave after retire", 64'(q_slot.size()), 64'd11);
      chk(q_slot[10] == 3, "R8", "reused slot", 64'(q_slot[10]), 64'd3);
      chk(q_base[10] == 12, "R4", "reused block", 64'(q_base[10]), 64'd12);
      chk(q_mask[10] == 64'h3FF, "R2", "ten-lane mask", q_mask[10], 64'h3FF);
      chk(launch_ready == 1'b1, "R6", "ready after last wave", 64'(launch_ready), 64'd1);
      for (int s = 0; s < NS; s++) retire(s);

      // R4 register budget limits occupancy
      clear_log();
      launch(192, 200, 32'h3000);
      idle(10);
      chk(q_slot.size() == 1, "R4", "heavy waves placed", 64'(q_slot.size()), 64'd1);
      chk(occupancy == 4'd1, "R4", "heavy occupancy", 64'(occupancy), 64'd1);
      retire(0);
      idle(2);
      chk(q_slot.size() == 2 && q_base[1] == 0, "R8", "heavy retry base", 64'(q_base[1]), 64'd0);
      retire(0);
      idle(3);
      chk(q_slot.size() == 3, "R2", "heavy wave count", 64'(q_slot.size()), 64'd3);
      retire(0);

      // R10 placement and retire in the same cycle
      launch(64, 4, 32'h40);
      settle();
      clear_log();
      @(negedge clk);
      launch_valid = 1'b1; launch_threads = 16'd192; launch_regs = 8'd4; launch_pc = 32'h44;
      @(negedge clk);
      launch_valid = 1'b0; retire_valid = 1'b1; retire_slot = 4'd0;
      @(negedge clk);
      retire_valid = 1'b0;
      settle();
      chk(q_slot.size() == 3, "R10", "waves in swap", 64'(q_slot.size()), 64'd3);
      chk(q_slot[0] == 1 && q_slot[1] == 0 && q_slot[2] == 2, "R10", "swap slot order",
          64'(q_slot[1]), 64'd0);
      chk(q_base[0] == 4 && q_base[1] == 0 && q_base[2] == 8, "R10", "swap bases",
          64'(q_base[2]), 64'd8);
      chk(occupancy == 4'd3, "R10", "occupancy after swap", 64'(occupancy), 64'd3);
      retire(0); retire(1); retire(2);

      // R4 first fit across a hole
      launch(256, 64, 32'h80);
      settle();
      retire(1);
      clear_log();
      launch(64, 20, 32'h84);
      settle();
      chk(q_slot[0] == 1 && q_base[0] == 64, "R4", "first fit in hole", 64'(q_base[0]), 64'd64);
      launch(64, 48, 32'h88);
      idle(6);
      chk(q_slot.size() == 1, "R4", "hole too small waits", 64'(q_slot.size()), 64'd1);
      retire(2);
      idle(3);
      chk(q_slot.size() == 2 && q_slot[1] == 2, "R4", "slot after merge", 64'(q_slot[1]), 64'd2);
      chk(q_base[1] == 84, "R4", "base after merge", 64'(q_base[1]), 64'd84);

      // R8 ignored retires
      retire(7);
      retire(12);
      idle(2);
      chk(occupancy == 4'd4, "R8", "ignored retires", 64'(occupancy), 64'd4);
      for (int s = 0; s < 4; s++) retire(s);
      idle(2);
      chk(occupancy == 4'd0, "R9", "final occupancy", 64'(occupancy), 64'd0);
      running = 1'b0;
   endtask

   initial begin
      fork
         main_seq();
         begin
            repeat (150000) @(posedge clk);
            n_bad++;
            $display("FAIL R7 watchdog expired act=%0d exp=%0d", 150000, 0);
         end
      join_any
      disable fork;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule